// File: doc/BRIEF.md
# Cartridge Wait-State Timer

This block turns a 16-bit wait-state control word into per-region access costs and then times each access. A bus master presents one request: a 4-bit region number, the access width, whether the access is sequential or a prefetch, whether it is a load or a store, and a burst length. The block works out the total number of cycles that access takes. It shows that count on `cost_o` and runs a down-counter. `ready_o` pulses on the last counted cycle.

The three cartridge windows and the save-memory region take their wait counts from fields of the control word. Their 32-bit costs are built from the 16-bit nonsequential (N) and sequential (S) values. The external work RAM region has fixed costs, and every other region has zero waits. A burst of several words is priced as one nonsequential 32-bit beat followed by sequential 32-bit beats.

Top module: `cart_wait_timer`

## Requirements
- R1: The 2-bit nonsequential code values 0, 1, 2 and 3 give 4, 3, 2 and 8 waits for a 16-bit nonsequential access. The codes sit in cfg[3:2] for window 0 (regions 8 and 9), in cfg[6:5] for window 1 (regions 10 and 11), in cfg[9:8] for window 2 (regions 12 and 13) and in cfg[1:0] for save memory (regions 14 and 15).
- R2: A 16-bit sequential access to window 0, 1 or 2 costs 1 wait when its sequential bit (cfg[4], cfg[7] or cfg[10]) is 1. When that bit is 0 it costs 2, 4 or 8 waits respectively.
- R3: For a window, a 32-bit nonsequential access costs N+1+S waits and a 32-bit sequential access costs 2S+1 waits. For save memory, every 16-bit access costs N waits and every 32-bit access costs 2N+1 waits.
- R4: A prefetch access (req_pref=1, which takes priority over req_seq) to a window costs 0 waits at either width when cfg[14] is 1, and the same as a sequential access when cfg[14] is 0. A prefetch to any other region costs the same as a sequential access.
- R5: After reset and before any write, the following hold for every access kind. Region 2 costs 2 waits at 16 bits and 5 waits at 32 bits. The windows and save memory behave as for a control word of 0. All other regions (0, 1 and 3 to 7) cost 0 waits.
- R6: A single access (req_len 0 or 1) costs 2 plus its wait count for a load and 1 plus its wait count for a store.
- R7: An access with req_len = k of 2 or more costs (1 + 32-bit nonsequential wait) + (k-1) x (1 + 32-bit sequential wait) of its region. Width, sequential, prefetch and direction inputs are ignored for such an access.
- R8: A request is accepted at a rising edge where req_valid is high and busy_o is low. busy_o is then high for exactly cost_o cycles starting with the next cycle, and ready_o is high only in the last of them.
- R9: A request presented while busy_o is high has no effect: it changes neither cost_o nor the ready timing, and it is not held for later.
- R10: A write with cfg_we at a rising edge does not affect a request accepted at that same edge. It applies to every request accepted at a later edge.
- R11: cost_o is 0 after reset. It loads the computed cost at each acceptance and holds it until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | New control word |
| req_valid | input | 1 | Access request |
| req_region | input | 4 | Region number of the access |
| req_wide | input | 1 | 1 for a 32-bit access, 0 for 16-bit |
| req_seq | input | 1 | Sequential access |
| req_pref | input | 1 | Prefetch access |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_len | input | LEN_W (4) | Burst length in words |
| busy_o | output | 1 | Access in progress |
| ready_o | output | 1 | Last cycle of the access |
| cost_o | output | LEN_W+5 (9) | Total cycles of the accepted access |

## Verification
One register lies between acceptance and both `cost_o` and `busy_o`, so the new cost is checked in the first cycle after the accepting edge. `ready_o` is expected in cycle number `cost` counted from that edge. The bench drives on falling edges and samples on falling edges. It counts the falling edges from acceptance until `ready_o` and compares that count with the cost it computes itself from the control word. For the same-edge write and the busy-time requests, the bench again looks only at these outputs in the cycles where they are due: the cost of the accepted access, the ready cycle, and `busy_o` staying low afterwards.

// File: rtl/cwt_pkg.sv
package cwt_pkg;
  localparam int WAIT_W     = 5;
  localparam int CFG_W      = 16;
  localparam int REGION_W   = 4;
  localparam int NUM_WIN    = 3;
  localparam int SRAM_LSB   = 0;
  localparam int WIN_LSB    = 2;
  localparam int WIN_STRIDE = 3;
  localparam int PF_BIT     = 14;
  localparam int WIN_PAIR0  = 4;

  localparam logic [REGION_W-1:0] REG_XRAM  = 4'd2;
  localparam logic [REGION_W-1:0] REG_SRAM0 = 4'd14;
  localparam logic [REGION_W-1:0] REG_SRAM1 = 4'd15;

  typedef logic [WAIT_W-1:0] wait_t;

  typedef struct packed {
    wait_t n16;
    wait_t s16;
    wait_t p16;
    wait_t n32;
    wait_t s32;
    wait_t p32;
  } wait_set_t;

  function automatic wait_t nonseq_waits(input logic [1:0] code);
    case (code)
      2'd0:    return wait_t'(4);
      2'd1:    return wait_t'(3);
      2'd2:    return wait_t'(2);
      default: return wait_t'(8);
    endcase
  endfunction

  function automatic wait_t seq_waits(input int win, input logic fast);
    if (fast) return wait_t'(1);
    return wait_t'(2 << win);
  endfunction
endpackage

// File: rtl/cwt_rst_sync.sv
module cwt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cwt_cfg_reg.sv
module cwt_cfg_reg
  import cwt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg
);
  logic [CFG_W-1:0] cfg_q, cfg_nxt;

  always_comb begin
    cfg_nxt = cfg_q;
    if (we) cfg_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_nxt;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/cwt_wait_table.sv
module cwt_wait_table
  import cwt_pkg::*;
(
  input  logic [CFG_W-1:0]    cfg,
  input  logic [REGION_W-1:0] region,
  output wait_set_t           waits
);
  wait_set_t win_ws [NUM_WIN];
  wait_set_t sram_ws;
  wait_set_t xram_ws;
  wait_t     sram_n;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int CODE_LSB = WIN_LSB + WIN_STRIDE * w;
    wait_t n16, s16, n32, s32;
    assign n16 = nonseq_waits(cfg[CODE_LSB +: 2]);
    assign s16 = seq_waits(w, cfg[CODE_LSB + 2]);
    assign n32 = n16 + wait_t'(1) + s16;
    assign s32 = (s16 << 1) + wait_t'(1);
    assign win_ws[w] = '{n16: n16, s16: s16,
                         p16: cfg[PF_BIT] ? wait_t'(0) : s16,
                         n32: n32, s32: s32,
                         p32: cfg[PF_BIT] ? wait_t'(0) : s32};
  end

  assign sram_n  = nonseq_waits(cfg[SRAM_LSB +: 2]);
  assign sram_ws = '{n16: sram_n, s16: sram_n, p16: sram_n,
                     n32: (sram_n << 1) + wait_t'(1),
                     s32: (sram_n << 1) + wait_t'(1),
                     p32: (sram_n << 1) + wait_t'(1)};
  assign xram_ws = '{n16: wait_t'(2), s16: wait_t'(2), p16: wait_t'(2),
                     n32: wait_t'(5), s32: wait_t'(5), p32: wait_t'(5)};

  always_comb begin
    waits = '0;
    if (region == REG_XRAM) waits = xram_ws;
    if (region == REG_SRAM0 || region == REG_SRAM1) waits = sram_ws;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (region[REGION_W-1:1] == (REGION_W-1)'(WIN_PAIR0 + w)) waits = win_ws[w];
    end
  end
endmodule

// File: rtl/cwt_cost_calc.sv
module cwt_cost_calc
  import cwt_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int COST_W = LEN_W + 5
) (
  input  wait_set_t          waits,
  input  logic               wide,
  input  logic               seq,
  input  logic               pref,
  input  logic               write,
  input  logic [LEN_W-1:0]   len,
  output logic [COST_W-1:0]  cost
);
  wait_t              sel_wait;
  logic [COST_W-1:0]  single_cost, first_beat, next_beat, tail_beats, burst_cost;
  logic               is_burst;

  always_comb begin
    if (pref)     sel_wait = wide ? waits.p32 : waits.p16;
    else if (seq) sel_wait = wide ? waits.s32 : waits.s16;
    else          sel_wait = wide ? waits.n32 : waits.n16;
  end

  always_comb begin
    single_cost = COST_W'(sel_wait) + (write ? COST_W'(1) : COST_W'(2));
    first_beat  = COST_W'(waits.n32) + COST_W'(1);
    next_beat   = COST_W'(waits.s32) + COST_W'(1);
    is_burst    = (len > LEN_W'(1));
    tail_beats  = COST_W'(len - LEN_W'(1));
    burst_cost  = first_beat + tail_beats * next_beat;
    cost        = is_burst ? burst_cost : single_cost;
  end
endmodule

// File: rtl/cwt_cycle_counter.sv
module cwt_cycle_counter #(
  parameter int COST_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COST_W-1:0] load_val,
  output logic              busy,
  output logic              last
);
  logic [COST_W-1:0] cnt_q, cnt_nxt;
  logic              busy_q, busy_nxt;
  logic              cnt_en;

  assign cnt_en = start | busy_q;
  assign last   = busy_q && (cnt_q == COST_W'(1));

  always_comb begin
    cnt_nxt  = cnt_q;
    busy_nxt = busy_q;
    if (start) begin
      cnt_nxt  = load_val;
      busy_nxt = 1'b1;
    end else if (busy_q) begin
      cnt_nxt  = cnt_q - COST_W'(1);
      busy_nxt = (cnt_q != COST_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_nxt;
      busy_q <= busy_nxt;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/cart_wait_timer.sv
module cart_wait_timer
  import cwt_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [15:0]        cfg_wdata,
  input  logic               req_valid,
  input  logic [3:0]         req_region,
  input  logic               req_wide,
  input  logic               req_seq,
  input  logic               req_pref,
  input  logic               req_write,
  input  logic [LEN_W-1:0]   req_len,
  output logic               busy_o,
  output logic               ready_o,
  output logic [LEN_W+4:0]   cost_o
);
  localparam int COST_W = LEN_W + 5;

  logic              rst_sync_n;
  logic [CFG_W-1:0]  cfg;
  wait_set_t         waits;
  logic [COST_W-1:0] cost_calc, cost_q;
  logic              accept, cost_en;

  cwt_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cwt_cfg_reg i_cfg_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  cwt_wait_table i_wait_table (
    .cfg    (cfg),
    .region (req_region),
    .waits  (waits)
  );

  cwt_cost_calc #(.LEN_W(LEN_W), .COST_W(COST_W)) i_cost_calc (
    .waits (waits),
    .wide  (req_wide),
    .seq   (req_seq),
    .pref  (req_pref),
    .write (req_write),
    .len   (req_len),
    .cost  (cost_calc)
  );

  assign accept  = req_valid && !busy_o;
  assign cost_en = accept;

  cwt_cycle_counter #(.COST_W(COST_W)) i_counter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (accept),
    .load_val (cost_calc),
    .busy     (busy_o),
    .last     (ready_o)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cost_q <= '0;
    else if (cost_en) cost_q <= cost_calc;
  end

  assign cost_o = cost_q;
endmodule

// File: rtl/cwt_checker.sv
module cwt_checker #(
  parameter int COST_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy_o,
  input logic              ready_o,
  input logic [COST_W-1:0] cost_o
);
  logic [COST_W-1:0] elapsed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     elapsed_q <= '0;
    else if (req_valid && !busy_o)  elapsed_q <= COST_W'(1);
    else if (busy_o)                elapsed_q <= elapsed_q + COST_W'(1);
  end

  AST_READY_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> busy_o); // R8
  AST_READY_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !busy_o); // R8
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy_o) |=> busy_o); // R8
  AST_READY_AT_COST: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (elapsed_q == cost_o)); // R8
  AST_BUSY_KEEPS_COST: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(cost_o)); // R9
  AST_IDLE_KEEPS_COST: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !req_valid) |=> $stable(cost_o)); // R11
  AST_COST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cost_o != '0)); // R6
endmodule

bind cart_wait_timer cwt_checker #(.COST_W(COST_W)) i_cwt_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .busy_o    (busy_o),
  .ready_o   (ready_o),
  .cost_o    (cost_o)
);

// File: tb/test_cart_wait_timer.sv
module test_cart_wait_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [15:0] cfg_wdata;
  logic       req_valid;
  logic [3:0] req_region;
  logic       req_wide, req_seq, req_pref, req_write;
  logic [3:0] req_len;
  logic       busy_o, ready_o;
  logic [8:0] cost_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] cur_cfg = 16'h0000;
  bit cfg_written = 1'b0;

  always #10 clk = ~clk;

  cart_wait_timer i_cart_wait_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_region(req_region), .req_wide(req_wide),
    .req_seq(req_seq), .req_pref(req_pref), .req_write(req_write),
    .req_len(req_len), .busy_o(busy_o), .ready_o(ready_o), .cost_o(cost_o)
  );

  function automatic int nmap(input int code);
    case (code)
      0: return 4;
      1: return 3;
      2: return 2;
      default: return 8;
    endcase
  endfunction

  // kind: 0 nonsequential, 1 sequential, 2 prefetch
  function automatic int exp_wait(input logic [15:0] cfg, input int region, input int kind, input bit wide);
    int w, n, s;
    if (region == 2) return wide ? 5 : 2;
    if (region >= 8 && region <= 13) begin
      w = (region - 8) / 2;
      n = nmap((cfg >> (2 + 3 * w)) & 3);
      s = ((cfg >> (4 + 3 * w)) & 1) != 0 ? 1 : (2 << w);
      if (kind == 2 && cfg[14]) return 0;
      if (kind != 0) return wide ? 2 * s + 1 : s;
      return wide ? n + 1 + s : n;
    end
    if (region >= 14) begin
      n = nmap(cfg & 3);
      return wide ? 2 * n + 1 : n;
    end
    return 0;
  endfunction

  function automatic int exp_cost(input logic [15:0] cfg, input int region, input int kind,
                                  input bit wide, input bit write, input int len);
    if (len > 1)
      return 1 + exp_wait(cfg, region, 0, 1) + (len - 1) * (1 + exp_wait(cfg, region, 1, 1));
    return (write ? 1 : 2) + exp_wait(cfg, region, kind, wide);
  endfunction

  function automatic string tag_for(input int kind, input bit wide, input int len, input bit written);
    if (len != 1) return "R7";
    if (!written) return "R5";
    if (kind == 2) return "R4";
    if (wide) return "R3";
    if (kind == 1) return "R2";
    return "R1";
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic set_req(input int region, input int kind, input bit wide, input bit write, input int len);
    req_region = 4'(region);
    req_seq    = (kind == 1);
    req_pref   = (kind == 2);
    req_wide   = wide;
    req_write  = write;
    req_len    = 4'(len);
  endtask

  task automatic run_access(input int region, input int kind, input bit wide, input bit write,
                            input int len, output int got_cost, output int got_cycles);
    int k;
    @(negedge clk);
    set_req(region, kind, wide, write, len);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    got_cost = int'(cost_o);
    while (!ready_o && k < 600) begin
      @(negedge clk);
      k++;
    end
    got_cycles = k;
  endtask

  task automatic access_check(input int region, input int kind, input bit wide, input bit write,
                              input int len, input string tag);
    int exp, gc, gk;
    exp = exp_cost(cur_cfg, region, kind, wide, write, len);
    run_access(region, kind, wide, write, len, gc, gk);
    check(gc == exp, tag, $sformatf("cost r%0d k%0d w%0d st%0d len%0d", region, kind, wide, write, len), gc, exp);
    check(gk == exp, "R8", $sformatf("ready cycle r%0d len%0d", region, len), gk, exp);
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = v;
    cfg_written = 1'b1;
  endtask

  task automatic sweep();
    int lens [4] = '{0, 2, 3, 15};
    int bregs [6] = '{0, 2, 8, 10, 12, 14};
    for (int r = 0; r < 16; r++)
      for (int k = 0; k < 3; k++)
        for (int wd = 0; wd < 2; wd++)
          for (int wr = 0; wr < 2; wr++)
            access_check(r, k, wd[0], wr[0], 1, tag_for(k, wd[0], 1, cfg_written));
    for (int b = 0; b < 6; b++)
      for (int l = 0; l < 4; l++)
        access_check(bregs[b], l % 3, l[0], l[1], lens[l], "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int gc, gk, ld, st, k;
    logic [15:0] v;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; req_valid = 1'b0;
    set_req(0, 0, 1'b0, 1'b0, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cost_o == 0, "R11", "reset cost", int'(cost_o), 0);
    check(busy_o == 0, "R8", "reset busy", int'(busy_o), 0);
    check(ready_o == 0, "R8", "reset ready", int'(ready_o), 0);

    // defaults before any write
    sweep();

    // R6: load versus store on the same access
    run_access(8, 0, 1'b0, 1'b0, 1, ld, gk);
    run_access(8, 0, 1'b0, 1'b1, 1, st, gk);
    check(ld == 6, "R6", "load cost win0", ld, 6);
    check(st == 5, "R6", "store cost win0", st, 5);

    // R9: requests while busy are dropped
    @(negedge clk);
    set_req(12, 0, 1'b1, 1'b0, 1);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    set_req(2, 0, 1'b0, 1'b1, 1);
    k = 1;
    while (!ready_o && k < 600) begin
      @(negedge clk);
      k++;
      if (k == 5) req_valid = 1'b0;
    end
    check(k == 15, "R9", "ready cycle with busy requests", k, 15);
    check(cost_o == 15, "R9", "cost with busy requests", int'(cost_o), 15);
    @(negedge clk);
    check(busy_o == 0, "R9", "busy after dropped request", int'(busy_o), 0);
    check(cost_o == 15, "R11", "cost held while idle", int'(cost_o), 15);

    // R10: write and request at the same edge
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = 16'h0007;
    set_req(8, 0, 1'b0, 1'b0, 1);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    req_valid = 1'b0;
    k = 1;
    while (!ready_o && k < 600) begin
      @(negedge clk);
      k++;
    end
    check(cost_o == 6, "R10", "same-edge write uses old word", int'(cost_o), 6);
    check(k == 6, "R10", "same-edge ready cycle", k, 6);
    cur_cfg = 16'h0007;
    cfg_written = 1'b1;
    access_check(8, 0, 1'b0, 1'b0, 1, "R10");

    // configuration sweep
    for (int c = 0; c < 8; c++) begin
      v = '0;
      v[1:0]  = 2'(c);
      v[3:2]  = 2'(c + 1);
      v[4]    = c[0];
      v[6:5]  = 2'(c + 2);
      v[7]    = c[1];
      v[9:8]  = 2'(c + 3);
      v[10]   = c[2] ^ c[0];
      v[14]   = c[2];
      write_cfg(v);
      sweep();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule